// File: doc/BRIEF.md
# Three-Phase Carrier Space-Vector Gate Generator

This block turns three signed phase reference samples into the six gate drives of a two-level, three-leg inverter. A symmetric up/down carrier counter is compared against one duty value per leg. Before the comparison, every phase reference receives the same offset: half of the reference whose value lies between the other two. This offset gives a triangular common-mode term that lets the phase voltages use the whole DC bus.

The duty values and the offset are captured only at the two turning points of the carrier. The offset, the carrier count, its direction and an update strobe are exported. A downstream common-mode compensator can use them to rebuild and cancel the switching-rate common-mode voltage. Each leg passes through its own dead-time stage. That stage holds both switches off for a programmable number of clock cycles before either switch turns on. The switching frequency is set by the carrier half period. At a 100 MHz clock, a half period of 5000 gives 10 kHz and a half period of 500 gives 100 kHz. Dead times such as 1% of the period, or 10 cycles (100 ns), fit in the dead-time field.

Top module: `svpwm_gen`

## Requirements
- R1: The carrier counts 0,1,...,P,P-1,...,1 and repeats, so one switching period is 2P cycles. P is `halfPeriod`, with a value of 0 treated as 1. P is taken up only while the carrier is at 0. After reset the carrier starts at 0 counting up. `carrierUp` is 1 from count 1 through count P on the rising ramp and 0 on the falling ramp.
- R2: `offsetRef` equals floor(mid/2), where mid is the middle value of the three signed references (`refA`, `refB`, `refC`).
- R3: The duty d of each leg is floor(P/2) + floor(((ref + floor(mid/2)) * P) / 2^REF_W), clamped to the range 0..P. In steady state the leg is high for 2d-1 cycles per period when d >= 1, and for 0 cycles when d = 0.
- R4: A leg state is 1 (upper gate on, lower off) when the carrier count is greater than P-d, and 0 otherwise. With zero dead time, the gates follow the carrier count with a latency of two cycles. Each period therefore runs all-low at the valley, then through the legs rising in order of decreasing duty to all-high at the peak, and back in reverse order.
- R5: Duties and `offsetRef` change only at a carrier turning point. `updStrobe` is a one-cycle pulse in the cycle in which new values become visible: one cycle after the carrier sat at 0, or at P while rising. Strobes are therefore P cycles apart.
- R6: When a leg state flips, both gates of that leg are low for exactly `deadTicks` cycles, and then the gate for the new state turns on. A gate that must turn off does so at once. In steady state, with a high run of H = 2d-1 and a low run of L = 2P-H, the upper gate is on for max(0, H-D) cycles per period and the lower gate for max(0, L-D). When d = 0, the lower gate is on for the full 2P cycles.
- R7: The upper and lower gates of a leg are never high together.
- R8: During reset, all gates, `offsetRef`, `carrierCnt` and `updStrobe` are 0. One cycle after reset is released, all lower gates are on.
- R9: A leg high run no longer than `deadTicks` never turns the upper gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refA | input | REF_W | Phase A signed reference |
| refB | input | REF_W | Phase B signed reference |
| refC | input | REF_W | Phase C signed reference |
| halfPeriod | input | CNT_W | Carrier half period P in cycles |
| deadTicks | input | DT_W | Dead time in cycles |
| gateHi | output | 3 | Upper gates, bit 0 = A, bit 1 = B, bit 2 = C |
| gateLo | output | 3 | Lower gates, same bit order |
| offsetRef | output | REF_W | Registered common offset floor(mid/2) |
| carrierCnt | output | CNT_W | Carrier count |
| carrierUp | output | 1 | Carrier direction, 1 while rising |
| updStrobe | output | 1 | Pulse when new duties and offset take effect |

## Verification
The hardest behaviour to show from the ports is that a reference change in the middle of a half period stays invisible until the next turning point. The stimulus therefore waits until the carrier is two counts into a rising ramp and then changes all three references. It confirms that `offsetRef` holds its old value for exactly P-1 cycles and changes in the strobe cycle. The second hard behaviour is a pulse swallowed by dead time. It is reached by choosing a reference whose duty is a single count, which gives a one-cycle high run, and setting a dead time equal to or longer than that run. All other checks come from sweeping reference triples, including clamping and equal values, across small half periods and several dead times, and predicting each gate cycle by cycle from the observed carrier.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  // Strobes from the carrier control to the datapath.
  typedef struct packed {
    logic load;    // carrier at a turning point: capture new duties
    logic valley;  // carrier at zero: period is being latched
  } ctrl_stb_t;
endpackage

// File: rtl/svpwm_ctrl.sv
module svpwm_ctrl
  import svpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic [CNT_W-1:0] periodReg,
  output logic [CNT_W-1:0] periodUse,
  output ctrl_stb_t        stb
);
  logic [CNT_W-1:0] periodIn;
  logic             atValley;
  logic             atPeak;

  assign periodIn  = (halfPeriod == '0) ? CNT_W'(1) : halfPeriod;
  assign atValley  = (cnt == '0);
  assign atPeak    = up && (cnt >= periodReg) && !atValley;
  assign periodUse = atValley ? periodIn : periodReg;

  always_comb begin
    stb.load   = atValley || atPeak;
    stb.valley = atValley;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      up        <= 1'b1;
      periodReg <= CNT_W'(1);
    end else if (atValley) begin
      up        <= 1'b1;
      cnt       <= CNT_W'(1);
      periodReg <= periodIn;
    end else if (atPeak) begin
      up  <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end else if (up) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/svpwm_datapath.sv
module svpwm_datapath
  import svpwm_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 16,
  parameter int LEGS  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] refs [LEGS],
  input  ctrl_stb_t               stb,
  input  logic        [CNT_W-1:0] periodUse,
  input  logic        [CNT_W-1:0] periodReg,
  input  logic        [CNT_W-1:0] cnt,
  output logic        [LEGS-1:0]  legState,
  output logic signed [REF_W-1:0] offsetRef,
  output logic                    updStrobe
);
  localparam int PW = REF_W + CNT_W + 2;

  logic signed [REF_W-1:0] loAB, hiAB, minHiC, midVal, offNext;
  logic        [CNT_W-1:0] dutyReg [LEGS];

  // Middle value of three: max(min(a,b), min(max(a,b), c)).
  always_comb begin
    loAB    = (refs[0] < refs[1]) ? refs[0] : refs[1];
    hiAB    = (refs[0] < refs[1]) ? refs[1] : refs[0];
    minHiC  = (hiAB < refs[2]) ? hiAB : refs[2];
    midVal  = (loAB > minHiC) ? loAB : minHiC;
    offNext = midVal >>> 1;
  end

  genvar g;
  generate
    for (g = 0; g < LEGS; g++) begin : gLeg
      logic signed [REF_W:0]  adj;
      logic signed [PW-1:0]   adjW, perW, halfW, prod, sum;
      logic        [CNT_W-1:0] dutyNext;
      logic        [CNT_W-1:0] thr;

      always_comb begin
        adj   = {refs[g][REF_W-1], refs[g]} + {offNext[REF_W-1], offNext};
        adjW  = PW'(adj);
        perW  = signed'(PW'({1'b0, periodUse}));
        halfW = signed'(PW'(periodUse >> 1));
        prod  = adjW * perW;
        sum   = (prod >>> REF_W) + halfW;
        if (sum < 0)
          dutyNext = '0;
        else if (sum > perW)
          dutyNext = periodUse;
        else
          dutyNext = sum[CNT_W-1:0];
      end

      assign thr = periodReg - dutyReg[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dutyReg[g]  <= '0;
          legState[g] <= 1'b0;
        end else begin
          if (stb.load) dutyReg[g] <= dutyNext;
          legState[g] <= (cnt > thr);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offsetRef <= '0;
      updStrobe <= 1'b0;
    end else begin
      updStrobe <= stb.load;
      if (stb.load) offsetRef <= offNext;
    end
  end
endmodule

// File: rtl/svpwm_deadtime.sv
module svpwm_deadtime #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            legIn,
  input  logic [DT_W-1:0] deadTicks,
  output logic            gHi,
  output logic            gLo
);
  logic            stateQ;
  logic [DT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= 1'b0;
      waitCnt <= DT_W'(1);
      gHi     <= 1'b0;
      gLo     <= 1'b0;
    end else if (legIn != stateQ) begin
      stateQ <= legIn;
      if (deadTicks == '0) begin
        gHi     <= legIn;
        gLo     <= ~legIn;
        waitCnt <= '0;
      end else begin
        gHi     <= 1'b0;
        gLo     <= 1'b0;
        waitCnt <= deadTicks;
      end
    end else if (waitCnt == DT_W'(1)) begin
      gHi     <= stateQ;
      gLo     <= ~stateQ;
      waitCnt <= '0;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - DT_W'(1);
    end
  end
endmodule

// File: rtl/svpwm_gen.sv
module svpwm_gen
  import svpwm_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic        [CNT_W-1:0] halfPeriod,
  input  logic        [DT_W-1:0]  deadTicks,
  output logic        [2:0]       gateHi,
  output logic        [2:0]       gateLo,
  output logic signed [REF_W-1:0] offsetRef,
  output logic        [CNT_W-1:0] carrierCnt,
  output logic                    carrierUp,
  output logic                    updStrobe
);
  localparam int LEGS = 3;

  ctrl_stb_t               stb;
  logic        [CNT_W-1:0] periodReg, periodUse;
  logic        [LEGS-1:0]  legState;
  logic signed [REF_W-1:0] refs [LEGS];

  assign refs[0] = refA;
  assign refs[1] = refB;
  assign refs[2] = refC;

  svpwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .halfPeriod(halfPeriod),
    .cnt(carrierCnt), .up(carrierUp), .periodReg(periodReg),
    .periodUse(periodUse), .stb(stb)
  );

  svpwm_datapath #(.REF_W(REF_W), .CNT_W(CNT_W), .LEGS(LEGS)) uData (
    .clk(clk), .rst_n(rst_n), .refs(refs), .stb(stb),
    .periodUse(periodUse), .periodReg(periodReg), .cnt(carrierCnt),
    .legState(legState), .offsetRef(offsetRef), .updStrobe(updStrobe)
  );

  genvar g;
  generate
    for (g = 0; g < LEGS; g++) begin : gDead
      svpwm_deadtime #(.DT_W(DT_W)) uDead (
        .clk(clk), .rst_n(rst_n), .legIn(legState[g]),
        .deadTicks(deadTicks), .gHi(gateHi[g]), .gLo(gateLo[g])
      );
    end
  endgenerate
endmodule

// File: rtl/svpwm_gen_checks.sv
module svpwm_gen_checks #(
  parameter int REF_W = 16,
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic        [DT_W-1:0]  deadTicks,
  input logic        [2:0]       gateHi,
  input logic        [2:0]       gateLo,
  input logic signed [REF_W-1:0] offsetRef,
  input logic        [CNT_W-1:0] carrierCnt,
  input logic                    carrierUp,
  input logic                    updStrobe
);
  // R1: carrier moves by exactly one count per cycle
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (carrierCnt == CNT_W'($past(carrierCnt) + CNT_W'(1))) ||
              (carrierCnt == CNT_W'($past(carrierCnt) - CNT_W'(1))));

  // R5: strobe only after a turning point
  a_r5_strobe_at_turn: assert property (@(posedge clk) disable iff (!rst_n)
    updStrobe |-> ($past(carrierCnt) == '0) || ($past(carrierUp) && !carrierUp));

  // R5: offset holds between strobes
  a_r5_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !updStrobe |-> $stable(offsetRef));

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : gLegChk
      // R7: no shoot-through
      a_r7_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        !(gateHi[g] && gateLo[g]));
      // R6: upper turn-on preceded by a low lower gate when dead time set
      a_r6_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gateHi[g]) && ($past(deadTicks) != '0)) |-> !$past(gateLo[g]));
      // R6: lower turn-on preceded by a low upper gate when dead time set
      a_r6_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gateLo[g]) && ($past(deadTicks) != '0)) |-> !$past(gateHi[g]));
    end
  endgenerate
endmodule

bind svpwm_gen svpwm_gen_checks #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .deadTicks(deadTicks), .gateHi(gateHi),
  .gateLo(gateLo), .offsetRef(offsetRef), .carrierCnt(carrierCnt),
  .carrierUp(carrierUp), .updStrobe(updStrobe)
);

// File: tb/tb_svpwm_gen.sv
module tb_svpwm_gen;
  localparam int REF_W = 16;
  localparam int CNT_W = 16;
  localparam int DT_W  = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst_n;
  logic signed [REF_W-1:0] refA, refB, refC;
  logic        [CNT_W-1:0] halfPeriod;
  logic        [DT_W-1:0]  deadTicks;
  logic        [2:0]       gateHi, gateLo;
  logic signed [REF_W-1:0] offsetRef;
  logic        [CNT_W-1:0] carrierCnt;
  logic                    carrierUp, updStrobe;

  int checks = 0;
  int fails  = 0;

  svpwm_gen #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .refA(refA), .refB(refB), .refC(refC),
    .halfPeriod(halfPeriod), .deadTicks(deadTicks), .gateHi(gateHi),
    .gateLo(gateLo), .offsetRef(offsetRef), .carrierCnt(carrierCnt),
    .carrierUp(carrierUp), .updStrobe(updStrobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint mid3(longint a, longint b, longint c);
    longint lo, hi, mh;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    mh = (hi < c) ? hi : c;
    return (lo > mh) ? lo : mh;
  endfunction

  function automatic longint expDuty(longint r, longint m, longint p);
    longint d;
    d = (p >>> 1) + (((r + (m >>> 1)) * p) >>> REF_W);
    if (d < 0) d = 0;
    if (d > p) d = p;
    return d;
  endfunction

  function automatic longint triple(int j, int k);
    longint t[3];
    case (j)
      0: t = '{20000, -10000, -10000};
      1: t = '{32767, -32768, 0};
      2: t = '{0, 0, 0};
      3: t = '{-26000, 0, 0};
      4: t = '{12000, 15000, -27000};
      5: t = '{-5000, 30000, -25000};
      6: t = '{32767, 32767, 32767};
      default: t = '{-32768, -32768, -32768};
    endcase
    return t[k];
  endfunction

  task automatic waitStrobes(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (updStrobe) seen++;
    end
  endtask

  task automatic runConfig(input int j, input int p);
    longint r[3], d[3], m;
    longint c1, c2;
    int mismHi[3], mismLo[3], hiCnt[3], loCnt[3];
    int overlap;
    @(negedge clk);
    for (int k = 0; k < 3; k++) r[k] = triple(j, k);
    refA = REF_W'(r[0]); refB = REF_W'(r[1]); refC = REF_W'(r[2]);
    halfPeriod = CNT_W'(p);
    deadTicks = '0;
    waitStrobes(3);
    repeat (3) @(negedge clk);
    m = mid3(r[0], r[1], r[2]);
    chk(longint'(offsetRef) == (m >>> 1), "R2", "offsetRef", longint'(offsetRef), m >>> 1);
    for (int k = 0; k < 3; k++) d[k] = expDuty(r[k], m, p);

    // Zero dead time: cycle-exact gate prediction from the carrier
    for (int k = 0; k < 3; k++) begin mismHi[k] = 0; mismLo[k] = 0; hiCnt[k] = 0; end
    c2 = carrierCnt;
    @(negedge clk);
    c1 = carrierCnt;
    for (int t = 0; t < 2 * p; t++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        bit e;
        e = (c2 > p - d[k]);
        if (gateHi[k] != e) mismHi[k]++;
        if (gateLo[k] != !e) mismLo[k]++;
        if (gateHi[k]) hiCnt[k]++;
      end
      c2 = c1;
      c1 = carrierCnt;
    end
    for (int k = 0; k < 3; k++) begin
      longint eh;
      eh = (d[k] == 0) ? 0 : 2 * d[k] - 1;
      chk(mismHi[k] == 0, "R4", "upper gate mismatches", mismHi[k], 0);
      chk(mismLo[k] == 0, "R4", "lower gate mismatches", mismLo[k], 0);
      chk(hiCnt[k] == eh, "R3", "high cycles per period", hiCnt[k], eh);
    end

    // Nonzero dead times: on-time per period
    for (int dt = 1; dt <= 3; dt += 2) begin
      @(negedge clk);
      deadTicks = DT_W'(dt);
      repeat (2 * p + 8) @(negedge clk);
      overlap = 0;
      for (int k = 0; k < 3; k++) begin hiCnt[k] = 0; loCnt[k] = 0; end
      for (int t = 0; t < 2 * p; t++) begin
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          if (gateHi[k]) hiCnt[k]++;
          if (gateLo[k]) loCnt[k]++;
          if (gateHi[k] && gateLo[k]) overlap++;
        end
      end
      for (int k = 0; k < 3; k++) begin
        longint h, l, eh, el;
        string rq;
        if (d[k] == 0) begin
          eh = 0; el = 2 * p;
        end else begin
          h = 2 * d[k] - 1; l = 2 * p - h;
          eh = (h > dt) ? h - dt : 0;
          el = (l > dt) ? l - dt : 0;
        end
        rq = (d[k] > 0 && 2 * d[k] - 1 <= dt) ? "R9" : "R6";
        chk(hiCnt[k] == eh, rq, "upper on-cycles", hiCnt[k], eh);
        chk(loCnt[k] == el, "R6", "lower on-cycles", loCnt[k], el);
      end
      chk(overlap == 0, "R7", "overlap cycles", overlap, 0);
    end
  endtask

  task automatic carrierShape(input int hp, input int p);
    int bad = 0;
    int badUp = 0;
    int gap, last;
    @(negedge clk);
    halfPeriod = CNT_W'(hp);
    deadTicks = '0;
    waitStrobes(3);
    while (carrierCnt != '0) @(negedge clk);
    for (int k = 0; k < 2 * p; k++) begin
      int e;
      e = (k <= p) ? k : 2 * p - k;
      if (int'(carrierCnt) != e) bad++;
      if (k >= 1 && carrierUp != (k <= p)) badUp++;
      @(negedge clk);
    end
    chk(bad == 0, "R1", "carrier count mismatches", bad, 0);
    chk(badUp == 0, "R1", "carrier direction mismatches", badUp, 0);
    // R5: strobe spacing equals the half period
    waitStrobes(1);
    last = 0; gap = 0;
    for (int s = 0; s < 4; s++) begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!updStrobe);
      if (n != p) gap++;
      last = n;
    end
    chk(gap == 0, "R5", "strobe spacing", last, p);
  endtask

  task automatic midHalfChange();
    longint oldOff, newOff;
    int n;
    bit held;
    @(negedge clk);
    refA = 16'sd20000; refB = -16'sd10000; refC = -16'sd10000;
    halfPeriod = CNT_W'(21);
    waitStrobes(3);
    @(negedge clk);
    oldOff = longint'(offsetRef);
    while (!(carrierUp && carrierCnt == CNT_W'(2))) @(negedge clk);
    refA = 16'sd12000; refB = 16'sd15000; refC = -16'sd27000;
    newOff = 12000 >>> 1;
    held = 1; n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!updStrobe && longint'(offsetRef) != oldOff) held = 0;
    end while (!updStrobe && n < 100);
    chk(held, "R5", "offset held before strobe", 0, 1);
    chk(n == 20, "R5", "cycles to strobe", n, 20);
    chk(longint'(offsetRef) == newOff, "R5", "offset at strobe", longint'(offsetRef), newOff);
  endtask

  initial begin
    rst_n = 1'b0;
    refA = '0; refB = '0; refC = '0;
    halfPeriod = CNT_W'(20);
    deadTicks = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(gateHi == 3'b000 && gateLo == 3'b000, "R8", "gates in reset", {gateHi, gateLo}, 0);
    chk(carrierCnt == '0 && !updStrobe, "R8", "carrier/strobe in reset", carrierCnt, 0);
    chk(offsetRef == '0, "R8", "offset in reset", offsetRef, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(gateLo == 3'b111 && gateHi == 3'b000, "R8", "lower gates after reset", {gateHi, gateLo}, 7);

    carrierShape(6, 6);
    carrierShape(0, 1);
    midHalfChange();
    for (int j = 0; j < 8; j++) begin
      runConfig(j, 2);
      runConfig(j, 9);
      runConfig(j, 21);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule